// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one memory instruction issued by a 32-lane warp and turns it into line-sized memory transactions. Each lane brings a byte address, a bit in an active mask, and a shared access-size code for the whole warp. The block collects active lanes whose addresses fall in the same 128-byte aligned line into one transaction. It then emits these transactions one per clock. Each transaction carries the line number and a mask of the lanes it serves.

A producer offers a warp on a ready/valid input. Once the warp is taken, the block presents transactions on a ready/valid output. The consumer can stall that output at any time. After the final transaction has been taken, a one-cycle done pulse closes the warp, and only then is a new warp accepted. A warp with no active lane closes at once with no transaction.

Every lane address is taken to be aligned to its access size, so a lane's access never crosses a line boundary. The 16-byte access size is handled per half-warp: lanes 0 to 15 and lanes 16 to 31 are never served by the same transaction in that mode.

Top module: `warp_coalescer`

## Requirements
- R1: Active lanes whose addresses share the same 128-byte line (address bits 31:7) are served by one transaction when the size code is 0 to 3 (1, 2, 4 or 8 bytes per lane).
- R2: The number of transactions for a warp equals the number of distinct lines touched by its active lanes, counted per half-warp for size code 4.
- R3: A lane whose in_mask bit is 0 appears in no transaction's out_lanes and adds no line.
- R4: Each transaction is led by the lowest-numbered active lane not yet served. Its out_lanes holds every unserved active lane in that leader's line, within the leader's half-warp for size code 4.
- R5: With size code 4 (16 bytes per lane), lanes 0 to 15 and lanes 16 to 31 are never combined. A broadcast of one address to all 32 lanes therefore takes two transactions, while any of codes 0 to 3 takes one.
- R6: While out_valid is high and out_ready is low, out_line and out_lanes hold their values. One transaction completes in every cycle where both are high.
- R7: done is a single-cycle pulse in the cycle after the last transaction is taken. out_valid is low in that cycle.
- R8: A warp with an all-zero in_mask produces no transaction, and done pulses in the cycle after it is accepted.
- R9: in_ready is high only in the idle state. It stays low from the accepting edge through the done cycle.
- R10: After reset, in_ready is 1, out_valid is 0 and done is 0.
- R11: out_line equals the leader's byte address shifted right by 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A warp request is offered |
| in_ready | output | 1 | Block is idle and takes a request |
| in_addr | input | 1024 | Lane byte addresses, lane i at bits 32*i+31:32*i |
| in_mask | input | 32 | Active lanes, bit i for lane i |
| in_size | input | 3 | Bytes per lane: 0=1, 1=2, 2=4, 3=8, 4=16, others as narrow |
| out_valid | output | 1 | A transaction is presented |
| out_ready | input | 1 | Consumer takes the transaction |
| out_line | output | 25 | Line number (byte address bits 31:7) |
| out_lanes | output | 32 | Lanes served by this transaction |
| done | output | 1 | One-cycle pulse closing the warp |

## Verification
The bound checker inspects every cycle. It checks that each transaction serves only unserved active lanes, that the transaction is led by the lowest such lane, and that a wide transaction never mixes half-warps. It also checks that done never arrives with lanes left over, that stalled output holds steady, and that the input stays closed while transactions are pending. Some properties can only be shown by the bench's scenarios, where the transactions are compared with a model: that lanes in one line are truly merged, and that the transaction count is minimal. Those scenarios include unit stride, an offset of one element, broadcast, large stride, an all-inactive warp and random backpressure.

// File: rtl/coal_pkg.sv
package coal_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_FIN   = 2'd2
    } coal_state_e;

    localparam int          SIZE_W    = 3;
    localparam logic [2:0]  SIZE_WIDE = 3'd4;

    typedef struct packed {
        logic take;
        logic fire;
        logic last;
    } coal_ctl_t;

    function automatic logic size_is_wide(input logic [SIZE_W-1:0] code);
        return code == SIZE_WIDE;
    endfunction

endpackage

// File: rtl/coal_lane_store.sv
module coal_lane_store
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_SHIFT = 7,
    localparam int LINE_W    = ADDR_W - LINE_SHIFT
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    load,
    input  logic [LANES*ADDR_W-1:0] addr_in,
    input  logic [LANES-1:0]        mask_in,
    input  logic [SIZE_W-1:0]       size_in,
    input  logic                    clear_en,
    input  logic [LANES-1:0]        clear_mask,
    output logic [LINE_W-1:0]       line_q [LANES],
    output logic [LANES-1:0]        pend_q,
    output logic                    wide_q
);

    logic [LANES*LINE_SHIFT-1:0] unused_low;

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign unused_low[i*LINE_SHIFT +: LINE_SHIFT] = addr_in[i*ADDR_W +: LINE_SHIFT];

        always_ff @(posedge clk) begin
            if (rst) begin
                line_q[i] <= '0;
            end else if (load) begin
                line_q[i] <= addr_in[i*ADDR_W + LINE_SHIFT +: LINE_W];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            pend_q <= mask_in;
            wide_q <= size_is_wide(size_in);
        end else if (clear_en) begin
            pend_q <= pend_q & ~clear_mask;
        end
    end

endmodule

// File: rtl/coal_leader.sv
module coal_leader #(
    parameter int LANES = 32,
    localparam int IDX_W = $clog2(LANES)
) (
    input  logic [LANES-1:0] pend,
    output logic [IDX_W-1:0] lead_idx
);

    logic [LANES:0]   seen;
    logic [LANES-1:0] lead_oh;

    assign seen[0] = 1'b0;

    for (genvar i = 0; i < LANES; i++) begin : g_pri
        assign lead_oh[i]  = pend[i] & ~seen[i];
        assign seen[i+1]   = seen[i] | pend[i];
    end

    always_comb begin
        lead_idx = '0;
        for (int i = 0; i < LANES; i++) begin
            if (lead_oh[i]) begin
                lead_idx = lead_idx | IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int LANES   = 32,
    parameter int LINE_W  = 25,
    localparam int IDX_W  = $clog2(LANES),
    localparam int HALF   = LANES / 2
) (
    input  logic [LINE_W-1:0] line_q [LANES],
    input  logic [LANES-1:0]  pend,
    input  logic [IDX_W-1:0]  lead_idx,
    input  logic              wide,
    output logic [LINE_W-1:0] lead_line,
    output logic [LANES-1:0]  match
);

    logic lead_upper;

    assign lead_line  = line_q[lead_idx];
    assign lead_upper = (int'(lead_idx) >= HALF);

    for (genvar i = 0; i < LANES; i++) begin : g_cmp
        localparam logic UPPER = (i >= HALF);
        logic same_line;
        logic same_half;
        assign same_line = (line_q[i] == lead_line);
        assign same_half = (UPPER == lead_upper);
        assign match[i]  = pend[i] & same_line & (~wide | same_half);
    end

endmodule

// File: rtl/coal_ctrl.sv
module coal_ctrl
    import coal_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic in_valid,
    input  logic any_active,
    input  logic out_ready,
    input  logic last_group,
    output logic in_ready,
    output logic out_valid,
    output coal_ctl_t ctl,
    output logic done
);

    coal_state_e st_q, st_d;

    assign in_ready  = (st_q == ST_IDLE);
    assign out_valid = (st_q == ST_ISSUE);
    assign done      = (st_q == ST_FIN);

    assign ctl.take = in_valid & in_ready;
    assign ctl.fire = out_valid & out_ready;
    assign ctl.last = last_group;

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE: begin
                if (ctl.take) begin
                    st_d = any_active ? ST_ISSUE : ST_FIN;
                end
            end
            ST_ISSUE: begin
                if (ctl.fire && ctl.last) begin
                    st_d = ST_FIN;
                end
            end
            ST_FIN:  st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES      = 32,
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 128,
    localparam int LINE_SHIFT = $clog2(LINE_BYTES),
    localparam int LINE_W     = ADDR_W - LINE_SHIFT,
    localparam int IDX_W      = $clog2(LANES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [LANES*ADDR_W-1:0] in_addr,
    input  logic [LANES-1:0]        in_mask,
    input  logic [SIZE_W-1:0]       in_size,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LINE_W-1:0]       out_line,
    output logic [LANES-1:0]        out_lanes,
    output logic                    done
);

    logic [LINE_W-1:0] line_q [LANES];
    logic [LANES-1:0]  pend_q;
    logic              wide_q;
    logic [IDX_W-1:0]  lead_idx;
    logic [LINE_W-1:0] lead_line;
    logic [LANES-1:0]  match;
    logic              last_group;
    coal_ctl_t         ctl;

    assign last_group = ((pend_q & ~match) == '0);

    coal_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .any_active (|in_mask),
        .out_ready  (out_ready),
        .last_group (last_group),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .ctl        (ctl),
        .done       (done)
    );

    coal_lane_store #(
        .LANES      (LANES),
        .ADDR_W     (ADDR_W),
        .LINE_SHIFT (LINE_SHIFT)
    ) u_store (
        .clk        (clk),
        .rst        (rst),
        .load       (ctl.take),
        .addr_in    (in_addr),
        .mask_in    (in_mask),
        .size_in    (in_size),
        .clear_en   (ctl.fire),
        .clear_mask (match),
        .line_q     (line_q),
        .pend_q     (pend_q),
        .wide_q     (wide_q)
    );

    coal_leader #(
        .LANES (LANES)
    ) u_lead (
        .pend     (pend_q),
        .lead_idx (lead_idx)
    );

    coal_line_match #(
        .LANES  (LANES),
        .LINE_W (LINE_W)
    ) u_match (
        .line_q    (line_q),
        .pend      (pend_q),
        .lead_idx  (lead_idx),
        .wide      (wide_q),
        .lead_line (lead_line),
        .match     (match)
    );

    assign out_line  = lead_line;
    assign out_lanes = match;

endmodule

// File: rtl/coal_chk.sv
module coal_chk
    import coal_pkg::*;
#(
    parameter int LANES  = 32,
    parameter int LINE_W = 25,
    localparam int HALF  = LANES / 2
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              in_ready,
    input logic [LANES-1:0]  in_mask,
    input logic [SIZE_W-1:0] in_size,
    input logic              out_valid,
    input logic              out_ready,
    input logic [LINE_W-1:0] out_line,
    input logic [LANES-1:0]  out_lanes,
    input logic              done
);

    logic [LANES-1:0] acc_q;
    logic [LANES-1:0] served_q;
    logic             wide_c;
    logic [LANES-1:0] left_c;
    logic [LANES-1:0] below_lead;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            served_q <= '0;
            wide_c   <= 1'b0;
        end else if (in_valid && in_ready) begin
            acc_q    <= in_mask;
            served_q <= '0;
            wide_c   <= (in_size == SIZE_WIDE);
        end else if (out_valid && out_ready) begin
            served_q <= served_q | out_lanes;
        end
    end

    assign left_c     = acc_q & ~served_q;
    assign below_lead = (out_lanes & (~out_lanes + 1'b1)) - 1'b1;

    // R3
    only_unserved_active_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_lanes != '0) && ((out_lanes & ~left_c) == '0));

    // R4
    lowest_leader_chk: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((left_c & below_lead) == '0));

    // R5
    wide_half_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && wide_c) |-> (out_lanes[HALF-1:0] == '0 || out_lanes[LANES-1:HALF] == '0));

    // R6
    hold_on_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> out_valid && $stable(out_line) && $stable(out_lanes));

    // R7
    done_complete_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (left_c == '0) && !out_valid);

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9
    closed_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (out_valid || done) |-> !in_ready);

endmodule

bind warp_coalescer coal_chk #(
    .LANES  (LANES),
    .LINE_W (LINE_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_mask   (in_mask),
    .in_size   (in_size),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_line  (out_line),
    .out_lanes (out_lanes),
    .done      (done)
);

// File: tb/sim_warp_coalescer.sv
`timescale 1ns/1ps
module sim_warp_coalescer;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [N*32-1:0] in_addr = '0;
    logic [N-1:0]  in_mask = '0;
    logic [2:0]    in_size = '0;
    logic          out_valid;
    logic          out_ready = 1'b0;
    logic [24:0]   out_line;
    logic [N-1:0]  out_lanes;
    logic          done;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [31:0] ta [N];
    logic [N-1:0] tm;
    logic [2:0]   tsz;
    logic [24:0]  e_line  [N];
    logic [N-1:0] e_lanes [N];
    int           e_n;

    always #5 clk = ~clk;

    warp_coalescer u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
        .in_addr(in_addr), .in_mask(in_mask), .in_size(in_size),
        .out_valid(out_valid), .out_ready(out_ready), .out_line(out_line),
        .out_lanes(out_lanes), .done(done)
    );

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Model of R1, R2, R4, R5: serve lowest unserved lane, merge its line.
    function automatic void build_expect();
        logic [N-1:0] pend;
        bit wide;
        pend = tm;
        wide = (tsz == 3'd4);
        e_n = 0;
        while (pend != '0) begin
            int lead;
            logic [N-1:0] m;
            lead = 0;
            for (int i = N - 1; i >= 0; i--) if (pend[i]) lead = i;
            m = '0;
            for (int i = 0; i < N; i++) begin
                if (pend[i] && (ta[i][31:7] == ta[lead][31:7]) &&
                    (!wide || ((i / 16) == (lead / 16))))
                    m[i] = 1'b1;
            end
            e_line[e_n]  = ta[lead][31:7];
            e_lanes[e_n] = m;
            e_n++;
            pend = pend & ~m;
        end
    endfunction

    task automatic run_warp(input int rdy_pct, input string tag);
        int idx;
        int cyc;
        bit got_done;
        bit fired_last;
        build_expect();
        @(negedge clk);
        check(in_ready == 1'b1, {"R9 idle ready ", tag}, in_ready, 1);
        in_valid = 1'b1;
        in_mask  = tm;
        in_size  = tsz;
        for (int i = 0; i < N; i++) in_addr[i*32 +: 32] = ta[i];
        @(negedge clk);
        in_valid = 1'b0;
        idx = 0;
        cyc = 0;
        got_done = 1'b0;
        fired_last = (e_n == 0);
        while (!got_done && cyc < 400) begin
            out_ready = (($urandom % 100) < rdy_pct);
            if (done) begin
                got_done = 1'b1;
                // R7 / R8: pulse right after the final transfer
                check(fired_last, {"R7 done timing ", tag}, fired_last, 1);
                check(idx == e_n, {"R2 count ", tag}, idx, e_n);
                check(!out_valid, {"R7 quiet at done ", tag}, out_valid, 0);
            end else begin
                check(!in_ready, {"R9 busy ", tag}, in_ready, 0);
                if (out_valid) begin
                    if (idx >= e_n) begin
                        check(1'b0, {"R2 extra txn ", tag}, idx, e_n);
                    end else begin
                        check(out_line == e_line[idx], {"R11 line ", tag}, out_line, e_line[idx]);
                        check(out_lanes == e_lanes[idx], {"R4 lanes ", tag}, out_lanes, e_lanes[idx]);
                    end
                    if (out_ready) begin
                        idx++;
                        fired_last = (idx == e_n);
                    end else begin
                        fired_last = 1'b0;
                    end
                end else begin
                    check(1'b0, {"R6 no output while busy ", tag}, out_valid, 1);
                end
            end
            @(negedge clk);
            cyc++;
        end
        out_ready = 1'b0;
        check(got_done, {"R7 done seen ", tag}, got_done, 1);
    endtask

    task automatic fill(input logic [31:0] base, input int stride, input logic [N-1:0] m, input logic [2:0] sz);
        for (int i = 0; i < N; i++) ta[i] = base + 32'(i * stride);
        tm = m;
        tsz = sz;
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R10
        check(in_ready == 1'b1, "R10 reset in_ready", in_ready, 1);
        check(out_valid == 1'b0, "R10 reset out_valid", out_valid, 0);
        check(done == 1'b0, "R10 reset done", done, 0);

        // R1: unit stride 4-byte, aligned -> one transaction
        fill(32'h0000_1000, 4, '1, 3'd2);
        run_warp(100, "R1 unit stride");
        check(e_n == 1, "R1 model count", e_n, 1);
        // R2: offset by one element -> two lines
        fill(32'h0000_1004, 4, '1, 3'd2);
        run_warp(100, "R2 offset one");
        check(e_n == 2, "R2 model count", e_n, 2);
        // R1: all lanes same word, byte size
        fill(32'h0000_2040, 0, '1, 3'd0);
        run_warp(70, "R1 broadcast");
        // R5: 16-byte broadcast needs two transactions
        fill(32'h0000_2040, 0, '1, 3'd4);
        run_warp(100, "R5 wide broadcast");
        check(e_n == 2, "R5 model count", e_n, 2);
        // R5: contiguous 16-byte lanes
        fill(32'h0000_4000, 16, '1, 3'd4);
        run_warp(60, "R5 wide contiguous");
        // R2: stride of a line -> 32 transactions
        fill(32'h0001_0000, 128, '1, 3'd3);
        run_warp(50, "R2 line stride");
        // R8: nothing active
        fill(32'h0000_0000, 4, '0, 3'd2);
        run_warp(100, "R8 empty");
        // R3: inactive lanes with far addresses ignored
        fill(32'h0000_3000, 4, 32'h0000_FFFF, 3'd2);
        for (int i = 16; i < N; i++) ta[i] = 32'h8000_0000 + 32'(i * 256);
        run_warp(100, "R3 inactive far");
        // R4: scattered order, lane 0 inactive
        fill(32'h0000_5000, 4, 32'hFFFF_FFFE, 3'd1);
        for (int i = 0; i < N; i++) ta[i] = 32'h0000_5000 + 32'(((i * 7) % 3) * 128) + 32'(i * 2);
        run_warp(40, "R4 interleaved");
        // R6: heavy backpressure on random pattern
        for (int k = 0; k < 120; k++) begin
            logic [31:0] base;
            int bytes;
            tsz = 3'($urandom % 5);
            bytes = 1 << tsz;
            base = $urandom & 32'hFFFF_FF80;
            for (int i = 0; i < N; i++)
                ta[i] = base + (($urandom % 512) & ~32'(bytes - 1));
            tm = ((k % 3) == 0) ? '1 : $urandom;
            run_warp((k % 4 == 0) ? 20 : 80, "R6 random");
        end
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule